// File: doc/BRIEF.md
# Bus Mode Detect Debounce Filter

This block turns the outputs of a set of threshold comparators watching a differential-sense line into a qualified bus mode: single-ended, low-voltage differential (LVD) or high-voltage differential. The comparators are read as a four-bit thermometer code. A new mode is adopted only after the sensed level has held for a programmable qualification time, nominally 190 ms, counted in 1 ms ticks from a clock prescaler. Levels that fall in the hysteresis gaps between thresholds, and codes that are not clean thermometer patterns, are treated as "no change".

The qualified mode drives three one-hot status outputs and a registered terminator-enable output. The terminator is enabled only in LVD mode while the disconnect input is low. A high disconnect input turns termination off whatever the mode, and it does not disturb mode tracking. Comparator outputs pass through a configurable synchronizer before they are decoded.

Top module: `busmode_qualifier`

## Requirements
- R1: The thermometer code is decoded as follows: bit0 means above 0.5 V, bit1 means above 0.7 V, bit2 means above 1.9 V, and bit3 means above 2.4 V. Code 4'b0000 selects single-ended, code 4'b0011 selects LVD and code 4'b1111 selects high-voltage differential.
- R2: The gap codes 4'b0001 and 4'b0111, and every code that is not a thermometer pattern, leave both the pending candidate and the qualified mode unchanged.
- R3: A level held stable becomes the qualified mode exactly SYNC_STAGES + 1 + QUAL_MS*CLK_PER_MS clock cycles after it first appears at the input. It is not the qualified mode one cycle earlier.
- R4: A different valid level arriving before the delay expires restarts the qualification from zero with the newer level.
- R5: If the level returns to the qualified mode before the delay expires, the pending change is cancelled and the qualified mode stays as it was.
- R6: Exactly one of mode_se, mode_lvd and mode_hvd is high at all times. It is the one that names the qualified mode.
- R7: During and after reset the qualified mode is LVD, and term_en is low while reset is held.
- R8: term_en is high only when the qualified mode is LVD and disconnect is low. It follows a change of either one after one clock cycle.
- R9: While disconnect is high, term_en is low in every mode, and mode qualification goes on unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_thermo | input | 4 | Comparator thermometer code of the sense level |
| disconnect | input | 1 | High shuts termination off |
| mode_se | output | 1 | Qualified mode is single-ended |
| mode_lvd | output | 1 | Qualified mode is LVD |
| mode_hvd | output | 1 | Qualified mode is high-voltage differential |
| term_en | output | 1 | Terminator enable, registered |

## Verification
A vector table walks the bench through every transition among the three modes. It also applies both gap codes, a non-thermometer code and disconnect in both states. Each vector is sampled one cycle before and exactly at the qualification point, which separates an exact delay from one that is off by one. Directed sequences then apply a second level in the middle of the count, which must restart it. They apply a return to the current mode, which must cancel the pending change. They apply a gap code during a pending change, which must keep the original candidate and its timing. A single-cycle disconnect pulse checks the one-cycle response of term_en.

// File: rtl/busmode_pkg.sv
package busmode_pkg;

   typedef enum logic [1:0] {
      MODE_SE  = 2'd0,
      MODE_LVD = 2'd1,
      MODE_HVD = 2'd2
   } bus_mode_e;

   typedef struct packed {
      logic      valid;
      bus_mode_e mode;
   } level_t;

   localparam int SENSE_W = 4;
   localparam logic [SENSE_W-1:0] CODE_SE  = 4'b0000;
   localparam logic [SENSE_W-1:0] CODE_LVD = 4'b0011;
   localparam logic [SENSE_W-1:0] CODE_HVD = 4'b1111;

   // Only the three clean band codes carry a mode; gaps and glitches do not.
   function automatic level_t classify(input logic [SENSE_W-1:0] code);
      level_t r;
      r.valid = 1'b1;
      r.mode  = MODE_LVD;
      case (code)
         CODE_SE:  r.mode = MODE_SE;
         CODE_LVD: r.mode = MODE_LVD;
         CODE_HVD: r.mode = MODE_HVD;
         default:  r.valid = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bm_tick_div.sv
module bm_tick_div #(
   parameter int CLK_PER_MS = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   localparam int DIV_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_MS - 1);

   logic [DIV_W-1:0] div_q;

   assign tick = (div_q == DIV_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || restart || tick) div_q <= '0;
      else                            div_q <= div_q + 1'b1;
   end

   generate
      if (CLK_PER_MS > 1) begin : g_gap_chk
         // R3: ticks are spaced, never back to back
         p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

   // R4: a restart lines the next tick up a full period later
   p_restart_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (div_q == '0));

endmodule

// File: rtl/bm_qualifier.sv
module bm_qualifier
   import busmode_pkg::*;
#(
   parameter int QUAL_MS = 190
) (
   input  logic      clk,
   input  logic      rst_n,
   input  level_t    lvl,
   input  logic      tick,
   output logic      restart,
   output bus_mode_e qual
);

   localparam int CNT_W = (QUAL_MS > 1) ? $clog2(QUAL_MS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_MS - 1);

   bus_mode_e        cand_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pending;

   assign restart = lvl.valid && (lvl.mode != cand_q);
   assign pending = (cand_q != qual);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q <= MODE_LVD;
         qual   <= MODE_LVD;
         cnt_q  <= '0;
      end else if (restart) begin
         cand_q <= lvl.mode;
         cnt_q  <= '0;
      end else if (pending && tick) begin
         if (cnt_q == CNT_LAST) begin
            qual  <= cand_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R3: the qualified mode moves only on a prescaler tick
   p_qual_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual != $past(qual)) |-> $past(tick));

   // R3: the counter never passes the programmed delay
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

   // R2: an invalid level leaves the candidate alone
   p_gap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl.valid |=> (cand_q == $past(cand_q)));

   // R5: with no pending change the counter rests at zero
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> (cnt_q == '0));

endmodule

// File: rtl/busmode_qualifier.sv
module busmode_qualifier
   import busmode_pkg::*;
#(
   parameter int CLK_PER_MS  = 100000,
   parameter int QUAL_MS     = 190,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SENSE_W-1:0] sense_thermo,
   input  logic               disconnect,
   output logic               mode_se,
   output logic               mode_lvd,
   output logic               mode_hvd,
   output logic               term_en
);

   generate
      if (CLK_PER_MS < 1) begin : g_bad_div
         $error("CLK_PER_MS must be at least 1");
      end
      if (QUAL_MS < 1) begin : g_bad_qual
         $error("QUAL_MS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [SENSE_W-1:0] sense_s;
   level_t             lvl;
   logic               tick;
   logic               restart;
   bus_mode_e          qual;

   bm_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES), .RST_VAL(CODE_LVD)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sense_thermo), .q(sense_s)
   );

   assign lvl = classify(sense_s);

   bm_tick_div #(.CLK_PER_MS(CLK_PER_MS)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
   );

   bm_qualifier #(.QUAL_MS(QUAL_MS)) u_qual (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .tick(tick),
      .restart(restart), .qual(qual)
   );

   assign mode_se  = (qual == MODE_SE);
   assign mode_lvd = (qual == MODE_LVD);
   assign mode_hvd = (qual == MODE_HVD);

   always_ff @(posedge clk) begin
      if (!rst_n) term_en <= 1'b0;
      else        term_en <= mode_lvd && !disconnect;
   end

   // R6: status outputs are one-hot
   p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mode_se, mode_lvd, mode_hvd}) == 1);

   // R8: enable follows a qualified LVD mode of the previous cycle
   p_term_lvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      term_en |-> $past(mode_lvd));

   // R9: raising disconnect drops the enable on the next cycle
   p_disc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disconnect) |=> !term_en);

endmodule

// File: tb/busmode_qualifier_bench.sv
module busmode_qualifier_bench;

   localparam int CPM  = 4;
   localparam int QMS  = 5;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1 + QMS * CPM;
   localparam int NVEC = 10;

   // {code[3:0], disconnect, expected mode[1:0] (0 SE,1 LVD,2 HVD), expected term_en}
   localparam logic [7:0] VEC [NVEC] = '{
      8'b0000_0_00_0,
      8'b0001_0_00_0,
      8'b1111_0_10_0,
      8'b0111_0_10_0,
      8'b0011_0_01_1,
      8'b0011_1_01_0,
      8'b0101_0_01_1,
      8'b1111_1_10_0,
      8'b0000_0_00_0,
      8'b0011_0_01_1
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] sense_thermo = 4'b0011;
   logic       disconnect = 1'b0;
   logic       mode_se, mode_lvd, mode_hvd, term_en;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   busmode_qualifier #(.CLK_PER_MS(CPM), .QUAL_MS(QMS), .SYNC_STAGES(SYNC)) u_busmode_qualifier (
      .clk(clk), .rst_n(rst_n), .sense_thermo(sense_thermo), .disconnect(disconnect),
      .mode_se(mode_se), .mode_lvd(mode_lvd), .mode_hvd(mode_hvd), .term_en(term_en)
   );

   function automatic logic [31:0] obs_mode();
      if ({mode_se, mode_lvd, mode_hvd} == 3'b100) return 0;
      if ({mode_se, mode_lvd, mode_hvd} == 3'b010) return 1;
      if ({mode_se, mode_lvd, mode_hvd} == 3'b001) return 2;
      return 3;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] prev;
      // R7: reset state
      step(3);
      chk("R7 mode in reset", obs_mode(), 1);
      chk("R7 term_en in reset", term_en, 0);
      rst_n = 1'b1;
      step(1);
      chk("R8 term_en after reset", term_en, 1);
      chk("R7 mode after reset", obs_mode(), 1);

      // R1 R2 R3 R6 R8 R9: vector walk
      prev = 1;
      for (int v = 0; v < NVEC; v++) begin
         sense_thermo = VEC[v][7:4];
         disconnect   = VEC[v][3];
         step(LAT - 1);
         chk("R3 old mode one cycle before expiry", obs_mode(), prev);
         step(1);
         chk("R1 qualified mode", obs_mode(), {30'd0, VEC[v][2:1]});
         chk("R6 one-hot count", $countones({mode_se, mode_lvd, mode_hvd}), 1);
         step(1);
         chk("R8 term_en per mode and disconnect", term_en, {31'd0, VEC[v][0]});
         prev = {30'd0, VEC[v][2:1]};
      end

      // R4: newer level restarts the count (now in LVD)
      sense_thermo = 4'b0000;
      step(10);
      sense_thermo = 4'b1111;
      step(LAT - 1);
      chk("R4 no switch before restarted expiry", obs_mode(), 1);
      step(1);
      chk("R4 newer level qualifies", obs_mode(), 2);

      // R5: return to current mode cancels (now in HVD)
      sense_thermo = 4'b0011;
      step(10);
      sense_thermo = 4'b1111;
      step(2 * LAT);
      chk("R5 pending change cancelled", obs_mode(), 2);

      // R2: gap code during pending keeps the candidate and its timing
      sense_thermo = 4'b0000;
      step(5);
      sense_thermo = 4'b0001;
      step(LAT - 6);
      chk("R2 still HVD before expiry", obs_mode(), 2);
      step(1);
      chk("R2 candidate kept through gap", obs_mode(), 0);

      // back to LVD, then a one-cycle disconnect pulse
      sense_thermo = 4'b0011;
      step(LAT + 1);
      chk("R8 term_en in LVD", term_en, 1);
      disconnect = 1'b1;
      step(1);
      chk("R9 disconnect drops term_en", term_en, 0);
      chk("R9 mode unaffected by disconnect", obs_mode(), 1);
      disconnect = 1'b0;
      step(1);
      chk("R8 term_en restored", term_en, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule